// File: doc/BRIEF.md
# Operand-Waiting Reservation Station

This block holds issued instructions in front of a single execution unit until their source operands exist. Each of its slots keeps an opcode and two operand fields. An operand field holds either a value or, if the value is still being computed, the tag of the station that will produce it. The block watches a broadcast result bus. When the bus carries a valid result whose tag matches a waiting operand, that operand takes the value straight from the bus. It does not wait for the register file write.

The execution unit signals whether it can accept work. When it can, the block hands over the oldest slot whose operands are both present. Oldest means earliest allocated. That slot becomes free at the same clock edge. While every slot is occupied, the block raises a stall toward fetch and ignores the issue port. A machine with several unit types uses one instance of this block per unit.

Top module: `rsv_station`

## Requirements
- R1: During and just after synchronous reset, no slot is occupied, `iss_stall` is 0 and `disp_valid` is 0.
- R2: An instruction presented with `iss_valid` high while `iss_stall` is low is written into the lowest-numbered free slot. It is later dispatched with the same opcode and operand values, and `disp_slot` gives that slot's index (0 to 3).
- R3: `disp_valid` is high only for a slot whose two operands both hold values.
- R4: While `eu_free` is low, nothing is dispatched, and a ready slot keeps its contents until `eu_free` returns high.
- R5: `iss_stall` is high exactly when all four slots are occupied. An instruction presented while it is high is discarded.
- R6: A waiting operand takes `res_value` in a cycle where `res_valid` is high and `res_tag` (3 bits) equals its stored tag. Any other tag, or `res_valid` low, leaves it waiting.
- R7: A slot whose last missing operand arrives on the result bus in cycle t is dispatched no earlier than cycle t+1. A slot issued with both operands present in cycle t can be dispatched from cycle t+1.
- R8: When several slots are ready and `eu_free` is high, the one allocated earliest is dispatched, whatever its index.
- R9: A dispatched slot is freed at that clock edge. `iss_stall` falls in the next cycle and the slot can be refilled then.
- R10: An instruction issued in the same cycle as a matching valid broadcast stores the broadcast value for that operand, not the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Opcode of the issued instruction |
| iss_a_rdy | input | 1 | First operand holds a value |
| iss_a_tag | input | 3 | Producer tag of first operand when not ready |
| iss_a_val | input | 16 | First operand value when ready |
| iss_b_rdy | input | 1 | Second operand holds a value |
| iss_b_tag | input | 3 | Producer tag of second operand when not ready |
| iss_b_val | input | 16 | Second operand value when ready |
| iss_stall | output | 1 | All slots occupied; hold fetch |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | 3 | Tag of the producing station |
| res_value | input | 16 | Broadcast result value |
| eu_free | input | 1 | Execution unit accepts an instruction this cycle |
| disp_valid | output | 1 | A slot is handed to the execution unit |
| disp_slot | output | 2 | Index of the dispatched slot |
| disp_op | output | 4 | Opcode of the dispatched slot |
| disp_a | output | 16 | First operand value |
| disp_b | output | 16 | Second operand value |

## Verification
The bench aims first at the timing of captures. It issues an instruction in the same cycle as its matching broadcast, which a design that latched the stale tag would leave waiting forever. It also checks that a slot is not dispatched in the very cycle its operand arrives; a design that bypassed the bus into the dispatch path would fail that check. Other cases hold a ready slot while the unit is busy and issue into a full station, where a design without gating would overwrite a live slot. The bench also arranges for a higher-indexed slot to be older than a lower one, so a plain index priority picks the wrong instruction.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int DATA_W    = 16;
    localparam int TAG_W     = 3;
    localparam int OP_W      = 4;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } rbus_t;

    typedef struct packed {
        logic [OP_W-1:0] op;
        opnd_t           a;
        opnd_t           b;
    } entry_t;

    // Fill a waiting operand from the result bus when the tags agree.
    function automatic opnd_t snoop(opnd_t o, rbus_t b);
        opnd_t r;
        r = o;
        if (!o.rdy && b.valid && (b.tag == o.tag)) begin
            r.rdy = 1'b1;
            r.val = b.value;
        end
        return r;
    endfunction

    // Index of the lowest set bit (0 when none is set).
    function automatic logic [SLOT_W-1:0] lowest_set(logic [NUM_SLOTS-1:0] v);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (v[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc,
    input  logic   rel,
    input  entry_t new_ent,
    input  rbus_t  bus,
    output logic   busy,
    output logic   ready,
    output entry_t ent
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ent  <= '0;
        end else if (alloc) begin
            busy   <= 1'b1;
            ent.op <= new_ent.op;
            ent.a  <= snoop(new_ent.a, bus);
            ent.b  <= snoop(new_ent.b, bus);
        end else begin
            if (busy) begin
                ent.a <= snoop(ent.a, bus);
                ent.b <= snoop(ent.b, bus);
            end
            if (rel) busy <= 1'b0;
        end
    end

    assign ready = busy & ent.a.rdy & ent.b.rdy;

    // R3
    rel_needs_operands_chk: assert property (@(posedge clk) disable iff (rst)
        rel |-> (busy && ent.a.rdy && ent.b.rdy));

    // R6
    snoop_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !alloc && !ent.a.rdy && bus.valid && (bus.tag == ent.a.tag))
        |=> (ent.a.rdy && (ent.a.val == $past(bus.value))));

    // R6
    snoop_miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !alloc && !ent.b.rdy && !(bus.valid && (bus.tag == ent.b.tag)))
        |=> !ent.b.rdy);

    // R10
    issue_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc && !new_ent.a.rdy && bus.valid && (bus.tag == new_ent.a.tag))
        |=> (ent.a.rdy && (ent.a.val == $past(bus.value))));
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  alloc_oh,
    input  logic [N-1:0]  busy,
    input  logic [N-1:0]  ready,
    input  logic          eu_free,
    output logic [N-1:0]  grant,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // older[i][j] set: slot i was allocated before slot j
    logic [N-1:0][N-1:0] older;

    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc_oh[i])      older[i][j] <= 1'b0;
                    else if (alloc_oh[j]) older[i][j] <= busy[i];
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant[i] = eu_free & ready[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && ready[j] && !older[i][j]) grant[i] = 1'b0;
            end
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    assign valid = |grant;

    // R8
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
endmodule

// File: rtl/rsv_station.sv
module rsv_station
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic              iss_a_rdy,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_rdy,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    output logic              iss_stall,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    input  logic              eu_free,
    output logic              disp_valid,
    output logic [SLOT_W-1:0] disp_slot,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b
);
    logic [NUM_SLOTS-1:0] busy, ready, grant, alloc_oh;
    entry_t               ents [NUM_SLOTS];
    entry_t               new_ent;
    rbus_t                bus;
    logic                 take;
    logic [SLOT_W-1:0]    alloc_idx;

    assign bus       = '{valid: res_valid, tag: res_tag, value: res_value};
    assign new_ent   = '{op: iss_op,
                         a:  '{rdy: iss_a_rdy, tag: iss_a_tag, val: iss_a_val},
                         b:  '{rdy: iss_b_rdy, tag: iss_b_tag, val: iss_b_val}};
    assign iss_stall = &busy;
    assign take      = iss_valid & ~iss_stall;
    assign alloc_idx = lowest_set(~busy);
    assign alloc_oh  = take ? (NUM_SLOTS'(1) << alloc_idx) : '0;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        rs_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .alloc   (alloc_oh[g]),
            .rel     (grant[g]),
            .new_ent (new_ent),
            .bus     (bus),
            .busy    (busy[g]),
            .ready   (ready[g]),
            .ent     (ents[g])
        );
    end

    rs_pick #(.N(NUM_SLOTS)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .alloc_oh (alloc_oh),
        .busy     (busy),
        .ready    (ready),
        .eu_free  (eu_free),
        .grant    (grant),
        .valid    (disp_valid),
        .idx      (disp_slot)
    );

    assign disp_op = ents[disp_slot].op;
    assign disp_a  = ents[disp_slot].a.val;
    assign disp_b  = ents[disp_slot].b.val;

    // R4
    unit_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !eu_free |=> ($countones(busy) >= $past($countones(busy))));

    // R5
    full_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        iss_stall |=> ($countones(busy) <= $past($countones(busy))));

    // R9
    dispatch_frees_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !busy[$past(disp_slot)]);
endmodule

// File: tb/tb_rsv_station.sv
`timescale 1ns/1ps
module tb_rsv_station;
    import rs_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic              iss_valid, iss_a_rdy, iss_b_rdy, res_valid, eu_free;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_a_tag, iss_b_tag, res_tag;
    logic [DATA_W-1:0] iss_a_val, iss_b_val, res_value;
    logic              iss_stall, disp_valid;
    logic [SLOT_W-1:0] disp_slot;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_a, disp_b;

    rsv_station dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_stall(iss_stall),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
        .eu_free(eu_free),
        .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Reference model of the slots
    bit                m_busy [NUM_SLOTS];
    logic [OP_W-1:0]   m_op   [NUM_SLOTS];
    bit                m_ar   [NUM_SLOTS], m_br [NUM_SLOTS];
    logic [TAG_W-1:0]  m_at   [NUM_SLOTS], m_bt [NUM_SLOTS];
    logic [DATA_W-1:0] m_av   [NUM_SLOTS], m_bv [NUM_SLOTS];
    int                m_seq  [NUM_SLOTS];
    int                seq_n;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NUM_SLOTS; i++) begin
            m_busy[i] = 0; m_ar[i] = 0; m_br[i] = 0; m_seq[i] = 0;
        end
        seq_n = 0;
    endfunction

    function automatic bit model_full();
        bit f = 1;
        for (int i = 0; i < NUM_SLOTS; i++) f &= m_busy[i];
        return f;
    endfunction

    // One cycle: drive inputs, check combinational outputs, advance model.
    task automatic step(bit iv, logic [OP_W-1:0] op,
                        bit ar, logic [TAG_W-1:0] at, logic [DATA_W-1:0] av,
                        bit br, logic [TAG_W-1:0] bt, logic [DATA_W-1:0] bv,
                        bit rv, logic [TAG_W-1:0] rt, logic [DATA_W-1:0] rval,
                        bit ef);
        int cand, fi;
        bit full, dv;
        @(negedge clk);
        iss_valid = iv; iss_op = op;
        iss_a_rdy = ar; iss_a_tag = at; iss_a_val = av;
        iss_b_rdy = br; iss_b_tag = bt; iss_b_val = bv;
        res_valid = rv; res_tag = rt; res_value = rval;
        eu_free = ef;
        #1;
        full = model_full();
        cand = -1;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (m_busy[i] && m_ar[i] && m_br[i] &&
                (cand < 0 || m_seq[i] < m_seq[cand])) cand = i;
        end
        dv = ef && (cand >= 0);
        chk("R5/R9 iss_stall", 32'(iss_stall), 32'(full));
        chk("R3/R4/R7 disp_valid", 32'(disp_valid), 32'(dv));
        if (dv) begin
            chk("R8 disp_slot", 32'(disp_slot), 32'(cand));
            chk("R2 disp_op", 32'(disp_op), 32'(m_op[cand]));
            chk("R6/R10 disp_a", 32'(disp_a), 32'(m_av[cand]));
            chk("R2/R6 disp_b", 32'(disp_b), 32'(m_bv[cand]));
        end
        // model edge
        fi = -1;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) if (!m_busy[i]) fi = i;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (m_busy[i]) begin
                if (!m_ar[i] && rv && rt == m_at[i]) begin m_ar[i] = 1; m_av[i] = rval; end
                if (!m_br[i] && rv && rt == m_bt[i]) begin m_br[i] = 1; m_bv[i] = rval; end
            end
        end
        if (dv) m_busy[cand] = 0;
        if (iv && !full) begin
            m_busy[fi] = 1; m_op[fi] = op;
            m_ar[fi] = ar; m_at[fi] = at; m_av[fi] = av;
            m_br[fi] = br; m_bt[fi] = bt; m_bv[fi] = bv;
            if (!ar && rv && rt == at) begin m_ar[fi] = 1; m_av[fi] = rval; end
            if (!br && rv && rt == bt) begin m_br[fi] = 1; m_bv[fi] = rval; end
            m_seq[fi] = seq_n; seq_n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before the stimulus finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        iss_valid = 0; iss_op = '0; iss_a_rdy = 0; iss_a_tag = '0; iss_a_val = '0;
        iss_b_rdy = 0; iss_b_tag = '0; iss_b_val = '0;
        res_valid = 0; res_tag = '0; res_value = '0; eu_free = 1;
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 stall in reset", 32'(iss_stall), 32'd0);
        chk("R1 disp_valid in reset", 32'(disp_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2: fill all four slots; first operand waits on tags 1..4
        for (int i = 0; i < NUM_SLOTS; i++)
            step(1, OP_W'(i + 1), 0, TAG_W'(i + 1), 16'h0, 1, 3'd0, 16'(100 + i), 0, 3'd0, 16'h0, 1);
        // R5: issue while full is dropped
        step(1, 4'd9, 1, 3'd0, 16'hdead, 1, 3'd0, 16'hbeef, 0, 3'd0, 16'h0, 1);
        // R6: non-matching tag leaves slots waiting
        step(0, 4'd0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 1, 3'd7, 16'h7777, 1);
        // R7: capture tag 3 into slot 2, no dispatch in this cycle
        step(0, 4'd0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 1, 3'd3, 16'h0333, 1);
        // R4: unit busy, ready slot held
        step(0, 4'd0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 0);
        step(0, 4'd0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 1);
        // R9 and R10: refill freed slot with same-cycle broadcast capture
        step(1, 4'd10, 0, 3'd5, 16'h0, 1, 3'd0, 16'h00aa, 1, 3'd5, 16'h0555, 0);
        // R8: slots 0,1,3 become ready while unit is busy; slot 2 is youngest
        step(0, 4'd0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 1, 3'd1, 16'h0111, 0);
        step(0, 4'd0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 1, 3'd4, 16'h0444, 0);
        step(0, 4'd0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 1, 3'd2, 16'h0222, 0);
        for (int i = 0; i < 5; i++)
            step(0, 4'd0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 0, 3'd0, 16'h0, 1);

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 100) < 55, OP_W'($urandom),
                 ($urandom % 2) == 0, TAG_W'($urandom), DATA_W'($urandom),
                 ($urandom % 3) == 0, TAG_W'($urandom), DATA_W'($urandom),
                 ($urandom % 100) < 60, TAG_W'($urandom), DATA_W'($urandom),
                 ($urandom % 100) < 70);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule